// File: doc/BRIEF.md
# Dual-Style Host Bus Front End

This block sits between an asynchronous parallel host bus and the internal logic of a small peripheral that holds clock registers and an additional 128-byte RAM bank. A static strap picks one of two bus conventions.

With the strap high, a data strobe times the cycle and a separate line gives its direction. With the strap low, the same two pins become separate active-low read and write strobes. The strobe pins, the direction pin and the active-low select pass through two-flop synchronisers into the system clock domain. Each qualified strobe edge becomes a single-cycle internal read or write pulse. The address, the write data and the bank choice are captured with that pulse.

The block also drives the output enable for the data bus during reads. It drops that enable in the same cycle that the synchronised read strobe or select goes inactive. While the active-low reset is held, every bus access is ignored.

Top module: `dual_style_bus_if`

## Requirements
- R1: While rst_n is low, rd_stb, wr_stb, bus_oe, bank_ext, addr_out and wdata_out are all 0, and strobe activity during reset produces no pulse, either then or after release.
- R2: With mode_sel=1 and cs_n=0, a rising edge on ds while rw=1 produces one rd_stb pulse, with addr_out equal to addr.
- R3: With mode_sel=1 and cs_n=0, a falling edge on ds while rw=0 produces one wr_stb pulse, with addr_out equal to addr and wdata_out equal to wdata.
- R4: With mode_sel=1, a rising ds edge while rw=0 and a falling ds edge while rw=1 produce no pulse of either kind.
- R5: With mode_sel=0 and cs_n=0, a falling edge on ds (the active-low read strobe) produces one rd_stb pulse and no wr_stb.
- R6: With mode_sel=0 and cs_n=0, a falling edge on rw (the active-low write strobe) produces no pulse, and the following rising edge produces one wr_stb pulse with wdata_out equal to wdata.
- R7: While cs_n=1, no strobe activity in either mode produces a pulse, and bus_oe stays 0.
- R8: bank_ext takes the value of bank_sel at the access, where 1 selects the extended RAM bank and 0 selects the clock registers.
- R9: bus_oe rises together with rd_stb and stays high while the read is held. Counted from the clock edge that follows the release of the read strobe or of cs_n, bus_oe is still 1 after one edge and 0 after the second.
- R10: A pulse goes high after the third rising clock edge following the qualifying pin change and lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; accesses are ignored while low |
| mode_sel | input | 1 | Static bus-style strap: 1 = strobe plus direction, 0 = split read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| ds | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw | input | 1 | Direction, 1 = read (mode 1), or active-low write strobe (mode 0) |
| bank_sel | input | 1 | 1 = extended RAM bank, 0 = clock registers |
| addr | input | AW | Host address |
| wdata | input | DW | Host write data |
| rd_stb | output | 1 | Single-cycle internal read pulse |
| wr_stb | output | 1 | Single-cycle internal write pulse |
| bank_ext | output | 1 | Bank captured with the last pulse |
| addr_out | output | AW | Address captured with the last pulse |
| wdata_out | output | DW | Write data captured with the last write pulse |
| bus_oe | output | 1 | Data-bus output enable during reads |

## Verification
The assertions assume that mode_sel stays fixed while a cycle is in progress. They also assume that cs_n goes low at least one clock before a strobe edge, and that addr, wdata and bank_sel stay stable from the strobe edge until the pulse has been taken. The bench changes inputs only on falling clock edges. It lowers cs_n two cycles before any strobe edge, and it changes the mode only while cs_n is high. It holds every strobe level for several cycles, so that each edge passes through the synchronisers as a single event.

// File: rtl/dual_style_bus_if.sv
module dual_style_bus_if #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          cs_n,
  input  logic          ds,
  input  logic          rw,
  input  logic          bank_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          bank_ext,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] wdata_out,
  output logic          bus_oe
);

  logic [2:0] ds_q, rw_q, cs_q;
  logic       oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q <= '0;
      rw_q <= '0;
      cs_q <= '1;
    end else begin
      ds_q <= {ds_q[1:0], ds};
      rw_q <= {rw_q[1:0], rw};
      cs_q <= {cs_q[1:0], cs_n};
    end
  end

  wire ds_s = ds_q[1];
  wire ds_p = ds_q[2];
  wire rw_s = rw_q[1];
  wire rw_p = rw_q[2];
  // select must have been seen for two synchronised cycles (blocks edges just after reset)
  wire sel  = ~cs_q[1] & ~cs_q[2];

  wire ds_rise = ds_s & ~ds_p;
  wire ds_fall = ~ds_s & ds_p;
  wire rw_rise = rw_s & ~rw_p;

  wire rd_hit  = sel & (mode_sel ? (ds_rise & rw_s) : ds_fall);
  wire wr_hit  = sel & (mode_sel ? (ds_fall & ~rw_s) : rw_rise);
  wire rd_hold = ~cs_q[1] & (mode_sel ? (ds_s & rw_s) : ~ds_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      bank_ext  <= 1'b0;
      addr_out  <= '0;
      wdata_out <= '0;
      oe_q      <= 1'b0;
    end else begin
      rd_stb <= rd_hit;
      wr_stb <= wr_hit;
      if (rd_hit || wr_hit) begin
        bank_ext <= bank_sel;
        addr_out <= addr;
      end
      if (wr_hit) wdata_out <= wdata;
      if (rd_hit) oe_q <= 1'b1;
      else if (!rd_hold) oe_q <= 1'b0;
    end
  end

  assign bus_oe = oe_q & rd_hold;

  p_rd_single_r10: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb);
  p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);
  p_rd_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |-> !$past(cs_n, 3));
  p_wr_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> !$past(cs_n, 3));
  p_oe_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> !$past(cs_n, 2));
  p_oe_start_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_oe) |-> rd_stb);

endmodule

// File: tb/dual_style_bus_if_test.sv
module dual_style_bus_if_test;
  localparam int AW = 7;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1, cs_n = 1'b1, ds = 1'b0, rw = 1'b1, bank_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic rd_stb, wr_stb, bank_ext, bus_oe;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] wdata_out;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;

  always #2.5 clk = ~clk;

  dual_style_bus_if #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .ds(ds), .rw(rw),
    .bank_sel(bank_sel), .addr(addr), .wdata(wdata), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .bank_ext(bank_ext), .addr_out(addr_out), .wdata_out(wdata_out), .bus_oe(bus_oe)
  );

  always @(negedge clk) begin
    if (rd_stb) rd_cnt++;
    if (wr_stb) wr_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(2);
    chk(rd_stb == 0 && wr_stb == 0 && bus_oe == 0, "R1 outputs in reset", {rd_stb, wr_stb, bus_oe}, 0);
    chk(addr_out == 0 && wdata_out == 0 && bank_ext == 0, "R1 captured fields in reset", addr_out, 0);
    cs_n = 0; addr = 7'h15; ds = 1; cyc(4); ds = 0; rw = 0; cyc(4); rw = 1; ds = 1; cyc(4);
    chk(rd_cnt == 0 && wr_cnt == 0, "R1 no pulse during reset", rd_cnt + wr_cnt, 0);
    rst_n = 1; cyc(8);
    chk(rd_cnt == 0 && wr_cnt == 0, "R1 no pulse after release", rd_cnt + wr_cnt, 0);
    ds = 0; cs_n = 1; cyc(6);
    rd_cnt = 0; wr_cnt = 0;
  endtask

  task automatic t_mh_read(input logic [AW-1:0] a, input logic b);
    int r0 = rd_cnt, w0 = wr_cnt;
    mode_sel = 1; rw = 1; ds = 0; addr = a; bank_sel = b; cs_n = 0; cyc(3);
    ds = 1; cyc(5);
    chk(rd_cnt == r0 + 1, "R2 one read pulse", rd_cnt - r0, 1);
    chk(addr_out == a, "R2 address", addr_out, a);
    chk(bank_ext == b, "R8 bank", bank_ext, b);
    chk(bus_oe == 1, "R9 oe held", bus_oe, 1);
    ds = 0;
    @(posedge clk); @(negedge clk);
    chk(bus_oe == 1, "R9 oe one edge after release", bus_oe, 1);
    @(negedge clk);
    chk(bus_oe == 0, "R9 oe two edges after release", bus_oe, 0);
    cyc(3);
    chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R4 falling ds with rw high", wr_cnt - w0, 0);
    cs_n = 1; cyc(3);
  endtask

  task automatic t_mh_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b);
    int r0 = rd_cnt, w0 = wr_cnt;
    mode_sel = 1; rw = 0; ds = 0; addr = a; wdata = d; bank_sel = b; cs_n = 0; cyc(3);
    ds = 1; cyc(5);
    chk(rd_cnt == r0 && wr_cnt == w0, "R4 rising ds with rw low", rd_cnt + wr_cnt - r0 - w0, 0);
    chk(bus_oe == 0, "R9 no oe on write", bus_oe, 0);
    ds = 0; cyc(5);
    chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R3 one write pulse", wr_cnt - w0, 1);
    chk(wdata_out == d, "R3 write data", wdata_out, d);
    chk(addr_out == a, "R3 address", addr_out, a);
    chk(bank_ext == b, "R8 bank", bank_ext, b);
    rw = 1; cs_n = 1; cyc(3);
  endtask

  task automatic t_ml_read(input logic [AW-1:0] a, input logic b);
    int r0 = rd_cnt, w0 = wr_cnt;
    mode_sel = 0; rw = 1; ds = 1; addr = a; bank_sel = b; cyc(4); cs_n = 0; cyc(3);
    ds = 0; cyc(5);
    chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R5 one read pulse", rd_cnt - r0, 1);
    chk(addr_out == a, "R5 address", addr_out, a);
    chk(bank_ext == b, "R8 bank", bank_ext, b);
    chk(bus_oe == 1, "R9 oe during read", bus_oe, 1);
    cs_n = 1;
    @(posedge clk); @(negedge clk);
    chk(bus_oe == 1, "R9 oe one edge after cs release", bus_oe, 1);
    @(negedge clk);
    chk(bus_oe == 0, "R9 oe two edges after cs release", bus_oe, 0);
    ds = 1; cyc(4);
    chk(rd_cnt == r0 + 1, "R5 no extra read", rd_cnt - r0, 1);
  endtask

  task automatic t_ml_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int r0 = rd_cnt, w0 = wr_cnt;
    mode_sel = 0; ds = 1; rw = 1; addr = a; wdata = d; bank_sel = 0; cs_n = 0; cyc(3);
    rw = 0; cyc(5);
    chk(wr_cnt == w0 && rd_cnt == r0, "R6 no pulse on falling write strobe", wr_cnt - w0, 0);
    rw = 1; cyc(5);
    chk(wr_cnt == w0 + 1, "R6 one write pulse", wr_cnt - w0, 1);
    chk(wdata_out == d, "R6 write data", wdata_out, d);
    chk(bank_ext == 0, "R8 register bank", bank_ext, 0);
    cs_n = 1; cyc(3);
  endtask

  task automatic t_cs_high;
    int r0 = rd_cnt, w0 = wr_cnt;
    bit oe_seen = 0;
    cs_n = 1;
    for (int m = 0; m < 2; m++) begin
      mode_sel = m[0]; cyc(4);
      for (int k = 0; k < 4; k++) begin
        ds = ~ds; cyc(4); oe_seen |= bus_oe;
        rw = ~rw; cyc(4); oe_seen |= bus_oe;
      end
    end
    chk(rd_cnt == r0 && wr_cnt == w0, "R7 no pulse with cs high", rd_cnt + wr_cnt - r0 - w0, 0);
    chk(!oe_seen, "R7 oe stays low with cs high", oe_seen, 0);
    ds = 0; rw = 1; cyc(4);
  endtask

  task automatic t_timing;
    bit [3:0] seen;
    mode_sel = 1; rw = 1; ds = 0; addr = 7'h33; cs_n = 0; cyc(4);
    ds = 1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      seen[i] = rd_stb;
    end
    chk(seen == 4'b0100, "R10 pulse after third edge for one cycle", seen, 4'b0100);
    ds = 0; cyc(4); cs_n = 1; cyc(3);
  endtask

  initial begin
    t_reset();
    t_mh_read(7'h05, 1'b0);
    t_mh_read(7'h7F, 1'b1);
    t_mh_write(7'h2A, 8'hC3, 1'b1);
    t_mh_write(7'h00, 8'h5A, 1'b0);
    t_ml_read(7'h41, 1'b1);
    t_ml_write(7'h12, 8'hA5);
    t_cs_high();
    t_timing();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule